// File: doc/BRIEF.md
# Interleaved Word/Nibble Converter

This block holds one 16-bit word and moves it to or from a 4-bit nibble bus, four bits per shift step. The word is seen as four 4-bit groups. Group j covers word bits 4j+3 down to 4j. Each group shifts right by one bit on every step. The lowest bit of group j drives nibble-out line j, and nibble-in line j enters at the top bit of group j. So each nibble collects every fourth bit of the word. It does not take a run of adjacent bits.

To unpack, load a word and give four shift strobes. Before step t, the nibble bus carries word bits 4j+t for each line j. To pack, present one nibble with each of four shift strobes. The finished word then appears on the parallel read port. The two directions share the register, so a single step both emits the out-taps and captures the in-taps. After the fourth step the converter reports done and ignores further strobes until a new word is loaded.

The word load is a valid/ready handshake. A load is accepted only in a cycle where `load_valid` and `load_ready` are both high. `load_ready` is high only while no conversion is in progress, which means after reset or after the fourth step. A word offered during a conversion is held back. The source must keep `load_valid` and `load_word` steady until the block accepts the word. The shift strobe and the done flag are plain level signals.

Top module: `nibble_weave`

## Requirements
- R1: After reset, `word_out` is 0, `done` is 1 and `load_ready` is 1.
- R2: In a cycle with `load_valid` and `load_ready` both high, the next cycle shows `word_out` equal to the offered `load_word` and `done` at 0.
- R3: While a conversion is in progress, `load_ready` is 0 and a raised `load_valid` leaves `word_out` unchanged.
- R4: `nib_out[j]` always equals `word_out[4j]`, for j = 0..3.
- R5: A shift strobe during a conversion moves every bit 4j+k to 4j+k-1 (k = 1..3) and writes `nib_in[j]` into bit 4j+3.
- R6: For a loaded word W, before step t (t = 0..3) `nib_out[j]` equals W[4j+t], and `done` rises right after the fourth step.
- R7: After four steps with nibbles N0..N3, `word_out[4j+t]` equals Nt[j].
- R8: A shift strobe while `done` is 1 leaves `word_out` and `done` unchanged.
- R9: In a cycle without a shift strobe or an accepted load, `word_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | A word is offered for loading |
| load_ready | output | 1 | The block can accept a word (idle or finished) |
| load_word | input | 16 | Word to load |
| shift | input | 1 | Step strobe: shift every group right by one bit |
| nib_in | input | 4 | Nibble captured at the group tops on a step |
| nib_out | output | 4 | Lowest bit of each group |
| word_out | output | 16 | Current register contents |
| done | output | 1 | Four steps completed since the last load |

## Verification
The assertions assume that `shift` and `load_valid` are driven to known levels in every cycle after reset. They also assume that an offered word stays stable until it is accepted. They do not assume that strobes are spaced apart. A strobe may arrive on consecutive cycles, in the cycle right after a load, or while the block is finished. The stimulus drives all inputs a short time after the rising edge. It mixes random words, random nibbles and random idle gaps between steps with directed cases: a load offered mid-conversion, and strobes given after completion.

// File: rtl/nw_pkg.sv
package nw_pkg;
  // Default geometry of the converter
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned NIB_W_DEF  = 4;
endpackage

// File: rtl/nw_lane.sv
// One interleave group: right shift register, serial in at top, out at bottom.
module nw_lane #(
  parameter int unsigned LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LANE_W-1:0] load_val,
  input  logic              step,
  input  logic              ser_in,
  output logic              ser_out,
  output logic [LANE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= load_val;
    else if (step)  q <= {ser_in, q[LANE_W-1:1]};
  end

  assign ser_out = q[0];

  // R9: the group holds when neither load nor step occurs
  a_r9_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(q));
endmodule

// File: rtl/nw_step_ctr.sv
// Counts accepted steps; a conversion ends after STEPS of them.
module nw_step_ctr #(
  parameter int unsigned STEPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic shift_req,
  output logic shift_go,
  output logic done
);
  localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;

  assign shift_go = shift_req && active && !load;
  assign done     = !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (shift_go) begin
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: completion is only ever reached through a step
  a_r6_done_from_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(shift_go));
  // R2: a load starts a conversion
  a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !done);
  // R8: a finished converter does not step
  a_r8_no_step_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !shift_go);
endmodule

// File: rtl/nibble_weave.sv
module nibble_weave #(
  parameter int unsigned WORD_W = nw_pkg::WORD_W_DEF,
  parameter int unsigned NIB_W  = nw_pkg::NIB_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [NIB_W-1:0]  nib_out,
  output logic [WORD_W-1:0] word_out,
  output logic              done
);
  localparam int unsigned LANE_W = WORD_W / NIB_W;

  logic load_fire;
  logic step_go;

  assign load_ready = done;
  assign load_fire  = load_valid && load_ready;

  nw_step_ctr #(.STEPS(LANE_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_fire),
    .shift_req (shift),
    .shift_go  (step_go),
    .done      (done)
  );

  for (genvar j = 0; j < NIB_W; j++) begin : g_lane
    nw_lane #(.LANE_W(LANE_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_fire),
      .load_val (load_word[j*LANE_W +: LANE_W]),
      .step     (step_go),
      .ser_in   (nib_in[j]),
      .ser_out  (nib_out[j]),
      .q        (word_out[j*LANE_W +: LANE_W])
    );

    // R4: each out line is the bottom tap of its group
    a_r4_tap: assert property (@(posedge clk) disable iff (!rst_n)
      nib_out[j] == word_out[j*LANE_W]);
    // R5: after a step, the out line shows the former next-higher bit
    a_r5_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !done) |=> nib_out[j] == $past(word_out[j*LANE_W + 1]));
  end

  // R2: an accepted word appears on the read port
  a_r2_load_word: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> word_out == $past(load_word));
  // R3: no word is taken while converting
  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !shift) |=> $stable(word_out));
  // R8: strobes after completion change nothing
  a_r8_idle_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load_valid) |=> $stable(word_out) && done);
endmodule

// File: tb/nibble_weave_bench.sv
module nibble_weave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [15:0] load_word = '0;
  logic        shift = 1'b0;
  logic [3:0]  nib_in = '0;
  logic [3:0]  nib_out;
  logic [15:0] word_out;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;
  int seed_dummy;

  always #5 clk = ~clk;

  nibble_weave u_nibble_weave (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_word(load_word), .shift(shift), .nib_in(nib_in), .nib_out(nib_out),
    .word_out(word_out), .done(done)
  );

  function automatic logic [15:0] model_step(logic [15:0] w, logic [3:0] n);
    logic [15:0] r;
    for (int j = 0; j < 4; j++) r[4*j +: 4] = {n[j], w[4*j+3 -: 3]};
    return r;
  endfunction

  function automatic logic [3:0] model_tap(logic [15:0] w, int t);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) r[j] = w[4*j+t];
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic load(logic [15:0] w);
    load_valid = 1'b1;
    load_word  = w;
    tick();
    load_valid = 1'b0;
    check(word_out == w && !done, "R2 load", word_out, w);
  endtask

  // Full conversion: unpack w while packing random nibbles
  task automatic convert(logic [15:0] w, bit gaps, bit busy_probe);
    logic [15:0] cur;
    logic [3:0]  nibs [4];
    load(w);
    cur = w;
    for (int t = 0; t < 4; t++) begin
      if (gaps) begin
        int g;
        g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) begin
          tick();
          check(word_out == cur, "R9 hold", word_out, cur);
        end
      end
      if (busy_probe && t == 2) begin
        check(!load_ready, "R3 ready low", {15'd0, load_ready}, 16'd0);
        load_valid = 1'b1;
        load_word  = ~cur;
        tick();
        load_valid = 1'b0;
        check(word_out == cur, "R3 load ignored", word_out, cur);
      end
      check(nib_out == model_tap(w, t), "R6 unpack tap",
            {12'd0, nib_out}, {12'd0, model_tap(w, t)});
      check(nib_out == model_tap(cur, 0), "R4 tap", {12'd0, nib_out},
            {12'd0, model_tap(cur, 0)});
      nibs[t] = 4'($urandom);
      nib_in  = nibs[t];
      shift   = 1'b1;
      tick();
      shift = 1'b0;
      cur = model_step(cur, nibs[t]);
      check(word_out == cur, "R5 step", word_out, cur);
      if (t < 3) check(!done, "R6 not yet done", {15'd0, done}, 16'd0);
    end
    check(done, "R6 done after four", {15'd0, done}, 16'd1);
    begin
      logic [15:0] pk;
      for (int j = 0; j < 4; j++)
        for (int t = 0; t < 4; t++) pk[4*j+t] = nibs[t][j];
      check(word_out == pk, "R7 packed word", word_out, pk);
    end
  endtask

  initial begin
    seed_dummy = $urandom(32'h5eed_0c1d);
    repeat (3) tick();
    check(word_out == 16'd0, "R1 reset word", word_out, 16'd0);
    check(done && load_ready, "R1 reset flags", {14'd0, done, load_ready}, 16'd3);
    rst_n = 1'b1;
    tick();
    // R8: strobe before any load
    shift = 1'b1; nib_in = 4'hF;
    tick();
    shift = 1'b0;
    check(word_out == 16'd0 && done, "R8 idle shift", word_out, 16'd0);
    // directed corners
    convert(16'h0000, 1'b0, 1'b0);
    convert(16'hFFFF, 1'b0, 1'b1);
    convert(16'h8421, 1'b1, 1'b0);
    convert(16'h1248, 1'b0, 1'b1);
    // R8: strobes after completion
    begin
      logic [15:0] keep;
      keep = word_out;
      shift = 1'b1; nib_in = 4'h5;
      tick(); tick();
      shift = 1'b0;
      check(word_out == keep && done, "R8 shift after done", word_out, keep);
    end
    // random traffic
    for (int i = 0; i < 60; i++)
      convert(16'($urandom), 1'b1, (i % 7) == 3);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule